// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Controller

This block is the device-side logic that follows the clock-enable pin of a synchronous DRAM. On every rising clock edge it samples CKE together with the four command pins. From these samples it tracks one of four modes: running, power-down, deep power-down, or clock suspend. It produces an internal clock-enable strobe that marks which internal edges really happen. It also keeps the column burst counter frozen across suppressed edges, reports which commands were accepted, and raises a flag when the array contents are lost and an initialization must run.

The effect of a low CKE depends on the state of the device. If no burst is running and all banks are idle, a low CKE with a no-operation command moves the device into power-down. A low CKE with the deep-power-down pattern moves it into deep power-down. If a burst is running, each low sample of CKE removes the next internal edge. On a removed edge the command decode and the burst counter stand still. After the block leaves power-down, commands are discarded for a configurable number of edges. After it leaves deep power-down, it waits for a mode-register load before it accepts normal commands again.

Top module: `sdram_cke_ctrl`

## Requirements
- R1: After reset, mode is running (0), init_req is 1, int_clk_en is 1, and burst_active, acc_valid and err are 0.
- R2: The command code is {cs_n,ras_n,cas_n,we_n}. NOP is 0111 and deselect is cs_n=1. On a live edge, any other command that is not masked gives acc_valid=1 with acc_cmd set to its code in the next cycle.
- R3: init_req clears on the cycle after a mode-register load (0000) is accepted.
- R4: While init_req is set, a live-edge command other than NOP, deselect, 0000, precharge (0010) or refresh (0001) is discarded, and err pulses in the next cycle. In deep power-down, any command other than NOP or deselect also pulses err.
- R5: A read (0101) or write (0100) sets burst_active with burst_cnt=0. Each later live edge advances burst_cnt, and burst_active drops on the live edge after burst_cnt reaches BURST_LEN-1.
- R6: A live edge that samples CKE low while a burst continues gives mode suspend (3) with dq_hold=1 and int_clk_en=0.
- R7: An edge that follows a CKE-low sample is suppressed. On a suppressed edge, burst_cnt holds and the command is ignored (no acc_valid).
- R8: A suppressed edge that samples CKE high returns mode to running. The next edge advances the burst again.
- R9: With all_idle=1, no burst and CKE low, a NOP on a live edge gives mode power-down (1). Commands are ignored while in that mode.
- R10: The edge that samples CKE high exits power-down. Non-NOP commands on the next CKE_SETUP edges are discarded.
- R11: With all_idle=1, no burst and CKE low, the code 0110 gives mode deep power-down (2). If all_idle=0, the same code is not treated as an entry.
- R12: The edge that samples CKE high exits deep power-down to running, with init_req=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| all_idle | input | 1 | All banks precharged |
| mode | output | 2 | 0 running, 1 power-down, 2 deep power-down, 3 suspend |
| int_clk_en | output | 1 | Next internal edge will be live |
| dq_hold | output | 1 | Data outputs hold their value |
| burst_active | output | 1 | Burst in progress |
| burst_cnt | output | CW | Current beat index |
| acc_valid | output | 1 | A command was accepted on the last edge |
| acc_cmd | output | 4 | Code of that command |
| init_req | output | 1 | Initialization required |
| err | output | 1 | Illegal command discarded |

## Verification
The hardest situation to reach is a burst that is already running when CKE drops. The stimulus issues a read and then lowers CKE on the very next edge. That edge still advances the counter, and the edge after it must freeze the counter and drop the write that is placed on the pins. After that, CKE rises on a suppressed edge, and the bench checks that the count resumes only one edge later. Reaching the power-down exit window and the post-deep-power-down init state also takes exact ordering of CKE against NOPs. The bench scripts this ordering edge by edge.

// File: rtl/sdram_cke_pkg.sv
package sdram_cke_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_PD   = 2'd1,
        MODE_DPD  = 2'd2,
        MODE_SUSP = 2'd3
    } pwr_mode_e;

    localparam logic [3:0] CODE_NOP  = 4'b0111;
    localparam logic [3:0] CODE_LMR  = 4'b0000;
    localparam logic [3:0] CODE_REF  = 4'b0001;
    localparam logic [3:0] CODE_PRE  = 4'b0010;
    localparam logic [3:0] CODE_DPD  = 4'b0110;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_cke_pkg::*;
(
    input  logic       cs_n,
    input  logic       ras_n,
    input  logic       cas_n,
    input  logic       we_n,
    output logic [3:0] code,
    output logic       is_idle_cmd,
    output logic       is_rw,
    output logic       is_lmr,
    output logic       is_dpd,
    output logic       init_ok
);
    always_comb begin
        code        = {cs_n, ras_n, cas_n, we_n};
        is_idle_cmd = cs_n || (code == CODE_NOP);
        is_rw       = !cs_n && (code[2:1] == 2'b10);
        is_lmr      = (code == CODE_LMR);
        is_dpd      = (code == CODE_DPD);
        init_ok     = is_idle_cmd || is_lmr || (code == CODE_PRE) || (code == CODE_REF);
    end
endmodule

// File: rtl/sdram_burst_ctr.sv
module sdram_burst_ctr #(
    parameter int BURST_LEN = 4,
    parameter int CW        = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    output logic          active,
    output logic [CW-1:0] cnt,
    output logic          last
);
    typedef struct packed {
        logic          active;
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        last  = ctr_q.active && (ctr_q.cnt == CW'(BURST_LEN - 1));
        if (start) begin
            ctr_d.active = 1'b1;
            ctr_d.cnt    = '0;
        end else if (tick && ctr_q.active) begin
            if (last) begin
                ctr_d.active = 1'b0;
                ctr_d.cnt    = '0;
            end else begin
                ctr_d.cnt = ctr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign active = ctr_q.active;
    assign cnt    = ctr_q.cnt;
endmodule

// File: rtl/sdram_cke_ctrl.sv
module sdram_cke_ctrl
    import sdram_cke_pkg::*;
#(
    parameter int BURST_LEN = 4,
    parameter int CKE_SETUP = 1,
    localparam int CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1,
    localparam int XW = $clog2(CKE_SETUP + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cke,
    input  logic          cs_n,
    input  logic          ras_n,
    input  logic          cas_n,
    input  logic          we_n,
    input  logic          all_idle,
    output logic [1:0]    mode,
    output logic          int_clk_en,
    output logic          dq_hold,
    output logic          burst_active,
    output logic [CW-1:0] burst_cnt,
    output logic          acc_valid,
    output logic [3:0]    acc_cmd,
    output logic          init_req,
    output logic          err
);
    typedef struct packed {
        pwr_mode_e     mode;
        logic          cke;
        logic          init_req;
        logic [XW-1:0] exit_cnt;
        logic          acc_valid;
        logic [3:0]    acc_cmd;
        logic          err;
    } st_t;

    st_t st_d, st_q;

    logic [3:0] code;
    logic       is_idle_cmd, is_rw, is_lmr, is_dpd, init_ok;
    logic       tick, start, b_active, b_last, b_continue;

    sdram_cmd_decode u_dec (
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .code(code), .is_idle_cmd(is_idle_cmd), .is_rw(is_rw),
        .is_lmr(is_lmr), .is_dpd(is_dpd), .init_ok(init_ok)
    );

    sdram_burst_ctr #(.BURST_LEN(BURST_LEN), .CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
        .active(b_active), .cnt(burst_cnt), .last(b_last)
    );

    always_comb begin
        st_d           = st_q;
        st_d.cke       = cke;
        st_d.acc_valid = 1'b0;
        st_d.acc_cmd   = '0;
        st_d.err       = 1'b0;
        tick           = 1'b0;
        start          = 1'b0;

        unique case (st_q.mode)
            MODE_RUN, MODE_SUSP: begin
                if (st_q.cke) begin
                    tick = 1'b1;
                    if (st_q.exit_cnt != '0)
                        st_d.exit_cnt = st_q.exit_cnt - 1'b1;
                    if (!cke && !b_active && all_idle && is_dpd) begin
                        st_d.mode = MODE_DPD;
                    end else if (!cke && !b_active && all_idle && is_idle_cmd) begin
                        st_d.mode = MODE_PD;
                    end else begin
                        if (st_q.init_req && !init_ok) begin
                            st_d.err = 1'b1;
                        end else if (st_q.exit_cnt == '0 && !is_idle_cmd) begin
                            st_d.acc_valid = 1'b1;
                            st_d.acc_cmd   = code;
                            start          = is_rw;
                            if (is_lmr) st_d.init_req = 1'b0;
                        end
                    end
                end
                if (st_d.mode == MODE_RUN || st_d.mode == MODE_SUSP)
                    st_d.mode = (!cke && b_continue) ? MODE_SUSP : MODE_RUN;
            end
            MODE_PD: begin
                if (cke) begin
                    st_d.mode     = MODE_RUN;
                    st_d.exit_cnt = XW'(CKE_SETUP);
                end
            end
            MODE_DPD: begin
                if (!is_idle_cmd) st_d.err = 1'b1;
                if (cke) begin
                    st_d.mode     = MODE_RUN;
                    st_d.init_req = 1'b1;
                end
            end
            default: st_d.mode = MODE_RUN;
        endcase
    end

    assign b_continue = start || (b_active && !(tick && b_last));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.mode     <= MODE_RUN;
            st_q.cke      <= 1'b1;
            st_q.init_req <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode         = st_q.mode;
    assign int_clk_en   = st_q.cke && (st_q.mode == MODE_RUN || st_q.mode == MODE_SUSP);
    assign dq_hold      = (st_q.mode == MODE_SUSP);
    assign burst_active = b_active;
    assign acc_valid    = st_q.acc_valid;
    assign acc_cmd      = st_q.acc_cmd;
    assign init_req     = st_q.init_req;
    assign err          = st_q.err;
endmodule

// File: rtl/sdram_cke_ctrl_chk.sv
module sdram_cke_ctrl_chk #(
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    mode,
    input logic          int_clk_en,
    input logic          dq_hold,
    input logic          burst_active,
    input logic [CW-1:0] burst_cnt,
    input logic          acc_valid,
    input logic          init_req,
    input logic          err
);
    a_r7_freeze_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_clk_en && burst_active) |=> $stable(burst_cnt));

    a_r7_no_accept_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !int_clk_en |=> !acc_valid);

    a_r4_err_discards: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !acc_valid);

    a_r12_dpd_exit_init: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2) |=> (mode == 2'd2) || (init_req && mode == 2'd0));

    a_r9_pd_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> !burst_active && !int_clk_en);

    a_r6_susp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3) |-> burst_active && dq_hold && !int_clk_en);
endmodule

bind sdram_cke_ctrl sdram_cke_ctrl_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .int_clk_en(int_clk_en),
    .dq_hold(dq_hold), .burst_active(burst_active), .burst_cnt(burst_cnt),
    .acc_valid(acc_valid), .init_req(init_req), .err(err)
);

// File: tb/sim_sdram_cke_ctrl.sv
module sim_sdram_cke_ctrl;
    localparam int BL = 4;
    localparam int CW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic all_idle = 1'b1;
    logic [1:0] mode;
    logic int_clk_en, dq_hold, burst_active, acc_valid, init_req, err;
    logic [CW-1:0] burst_cnt;
    logic [3:0] acc_cmd;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] exp_q[$];
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdram_cke_ctrl #(.BURST_LEN(BL), .CKE_SETUP(1)) u0 (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .all_idle(all_idle), .mode(mode),
        .int_clk_en(int_clk_en), .dq_hold(dq_hold), .burst_active(burst_active),
        .burst_cnt(burst_cnt), .acc_valid(acc_valid), .acc_cmd(acc_cmd),
        .init_req(init_req), .err(err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // drive one edge; push expected accepted command when acc is expected
    task automatic step(input logic k, input logic [3:0] c, input bit expect_acc);
        @(negedge clk);
        cke = k;
        {cs_n, ras_n, cas_n, we_n} = c;
        if (expect_acc) exp_q.push_back(c);
        @(posedge clk);
        #1;
    endtask

    // monitor: every accepted command must match the next queued one
    always @(negedge clk) begin
        if (rst_n && acc_valid) begin
            n_tests++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R2: actual acc %b expected none", acc_cmd);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                if (e != acc_cmd) begin
                    n_fail++;
                    $display("FAIL R2: actual acc %b expected %b", acc_cmd, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 mode", mode, 0);
        chk("R1 init_req", init_req, 1);
        chk("R1 int_clk_en", int_clk_en, 1);
        chk("R1 burst", burst_active, 0);
        chk("R1 err", err, 0);
        rst_n = 1'b1;

        // R4: read during init is rejected
        step(1, 4'b0101, 0);
        chk("R4 err", err, 1);
        chk("R4 no burst", burst_active, 0);
        step(1, 4'b0111, 0);
        chk("R4 err clear", err, 0);

        // R3: mode-register load clears init
        step(1, 4'b0000, 1);
        chk("R3 init clear", init_req, 0);
        step(1, 4'b0111, 0);

        // R5 plain burst
        step(1, 4'b0100, 1);
        chk("R5 active", burst_active, 1);
        chk("R5 cnt0", burst_cnt, 0);
        step(1, 4'b0111, 0); chk("R5 cnt1", burst_cnt, 1);
        step(1, 4'b0111, 0); chk("R5 cnt2", burst_cnt, 2);
        step(1, 4'b0111, 0); chk("R5 cnt3", burst_cnt, 3);
        step(1, 4'b0111, 0); chk("R5 done", burst_active, 0);

        // R6/R7/R8 clock suspend
        step(1, 4'b0101, 1);
        step(0, 4'b0111, 0);
        chk("R6 mode", mode, 3);
        chk("R6 dq_hold", dq_hold, 1);
        chk("R6 int_clk_en", int_clk_en, 0);
        chk("R6 cnt", burst_cnt, 1);
        step(0, 4'b0100, 0);
        chk("R7 frozen", burst_cnt, 1);
        chk("R7 still susp", mode, 3);
        step(1, 4'b0111, 0);
        chk("R8 mode run", mode, 0);
        chk("R8 cnt held", burst_cnt, 1);
        step(1, 4'b0111, 0);
        chk("R8 resumed", burst_cnt, 2);
        step(1, 4'b0111, 0);
        step(1, 4'b0111, 0);
        chk("R5 end after suspend", burst_active, 0);

        // R9/R10 power-down
        step(0, 4'b0111, 0);
        chk("R9 pd", mode, 1);
        chk("R9 clk gated", int_clk_en, 0);
        step(0, 4'b0011, 0);
        chk("R9 ignored", mode, 1);
        step(1, 4'b0111, 0);
        chk("R10 exit", mode, 0);
        step(1, 4'b0011, 0);
        chk("R10 discarded", acc_valid, 0);
        step(1, 4'b0011, 1);
        chk("R10 accepted", acc_valid, 1);

        // R11 with banks busy: no entry
        all_idle = 1'b0;
        step(0, 4'b0110, 1);
        chk("R11 busy no dpd", mode, 0);
        step(1, 4'b0111, 0);
        all_idle = 1'b1;

        // R11/R12/R4 deep power-down
        step(1, 4'b0111, 0);
        step(0, 4'b0110, 0);
        chk("R11 dpd", mode, 2);
        step(0, 4'b0101, 0);
        chk("R4 dpd err", err, 1);
        chk("R11 stays", mode, 2);
        step(1, 4'b0111, 0);
        chk("R12 exit", mode, 0);
        chk("R12 init", init_req, 1);
        step(1, 4'b0011, 0);
        chk("R4 init err", err, 1);
        chk("R4 no acc", acc_valid, 0);
        step(1, 4'b0000, 1);
        chk("R3 init clear 2", init_req, 0);
        step(1, 4'b0111, 0);
        step(1, 4'b0111, 0);

        chk("R2 queue drained", exp_q.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule